// File: doc/BRIEF.md
# H4 Multiframe Loss Detector

This block follows the four-frame multiframe of a SONET/SDH path. It takes the two low bits of the H4 byte once per frame, from an outside strobe, and compares each value with a two-bit reference counter. The counter advances once per received H4. The expected cycle is 0, 1, 2, 3, and then it repeats. While the detector is in lock, a run of errored multiframes raises a loss-of-multiframe alarm. While the detector is out of lock, the counter follows the incoming data. The detector locks again at whatever phase the data has, once a full correct cycle has been seen.

Two outputs carry the alarm. One is a live flag. The other is a sticky copy that records every rising edge of the live flag and is cleared by a read-clear pulse. A format enable and a mode-select control decide whether the detector runs. When it does not run, the live flag is forced to 0 and all tracking state is held at its reset values.

Top module: `h4mf_loss_detector`

## Requirements
- R1: During a synchronous reset with the detector enabled, `lom` and `lom_lat` are both 1 after the next edge.
- R2: While out of lock, the reference counter is loaded with the received value plus one (modulo 4). Loss clears on the fourth value in a row that equals its predecessor plus one, whatever the starting phase. A value that breaks the run starts a new run of length one.
- R3: In lock, one errored multiframe does not declare loss. A multiframe is errored when any of its four H4 values differs from the counter. A multiframe with no mismatches clears the error history.
- R4: In lock, loss is declared on the H4 that closes the second errored multiframe in a row. That H4 is the one compared while the counter holds 3.
- R5: In lock, the counter advances by one on every strobe whether the value matches or not, so multiframe boundaries follow the counter and not the data. Cycles without `h4_vld` change no output except through `rd_clr`.
- R6: `lom_lat` becomes 1 on the edge where `lom` rises. It stays 1 until a cycle with `rd_clr` high, which clears it on the next edge.
- R7: When `lom` rises in the same cycle that `rd_clr` is high, `lom_lat` ends up 1.
- R8: When `fmt_en` is 0 or `mode_sel` is 1, `lom` is 0 after the next edge and the state returns to its reset values. When the detector is enabled again, `lom` is 1 after the first edge.
- R9: Both outputs are registered. An H4 strobe sampled at one edge shows its effect on `lom` directly after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fmt_en | input | 1 | 1 when the format carries this channel's multiframe indicator |
| mode_sel | input | 1 | Detector runs only when this is 0 |
| h4_vld | input | 1 | One-cycle strobe for each received H4 byte |
| h4_val | input | 2 | Low two bits of the received H4 byte |
| rd_clr | input | 1 | Clears the sticky alarm copy |
| lom | output | 1 | Live loss-of-multiframe flag |
| lom_lat | output | 1 | Sticky copy of rising edges of `lom` |

## Verification
The assertions assume that `h4_vld` is a single-cycle strobe and that `h4_val` is only meaningful while the strobe is high. They also assume that changes of `fmt_en` or `mode_sel` are seen at a clock edge like any other input. Changes of the live flag are checked only across two cycles in which the detector stayed enabled. This keeps the forced value seen on re-enable out of the checks on data-driven transitions. The stimulus drives every input at the falling edge, holds `h4_val` fixed across each strobe, and toggles the enable controls only between strobes.

// File: rtl/h4mf_pkg.sv
package h4mf_pkg;
  localparam int H4W    = 2;
  localparam int MF_LEN = 1 << H4W;
  typedef logic [H4W-1:0] h4_t;
  localparam h4_t MF_LAST = h4_t'(MF_LEN - 1);

  function automatic h4_t h4_inc(input h4_t v);
    return v + h4_t'(1);
  endfunction
endpackage

// File: rtl/h4mf_lock_fsm.sv
module h4mf_lock_fsm
  import h4mf_pkg::*;
#(
  parameter int ERR_MF   = 2,
  parameter int LOCK_RUN = 4
) (
  input  logic clk,
  input  logic clr,
  input  logic vld,
  input  h4_t  val,
  output logic loss_d
);
  localparam int ECW = $clog2(ERR_MF + 1);
  localparam int RCW = $clog2(LOCK_RUN + 1);

  h4_t            ref_q, ref_n;
  logic           loss_q, loss_n;
  logic           mferr_q, mferr_n;
  logic [ECW-1:0] errc_q, errc_n;
  logic [RCW-1:0] run_q, run_n;
  logic           match, acc;

  assign match = (val == ref_q);
  assign acc   = mferr_q | ~match;

  always_comb begin
    ref_n   = ref_q;
    loss_n  = loss_q;
    mferr_n = mferr_q;
    errc_n  = errc_q;
    run_n   = run_q;
    if (vld) begin
      if (loss_q) begin
        ref_n = h4_inc(val);
        if (!match)
          run_n = RCW'(1);
        else if (run_q < RCW'(LOCK_RUN))
          run_n = run_q + RCW'(1);
        if (run_n == RCW'(LOCK_RUN)) begin
          loss_n  = 1'b0;
          run_n   = '0;
          errc_n  = '0;
          mferr_n = 1'b0;
        end
      end else begin
        ref_n = h4_inc(ref_q);
        if (ref_q == MF_LAST) begin
          mferr_n = 1'b0;
          if (!acc)
            errc_n = '0;
          else if (errc_q == ECW'(ERR_MF - 1)) begin
            loss_n = 1'b1;
            errc_n = '0;
            run_n  = '0;
          end else
            errc_n = errc_q + ECW'(1);
        end else
          mferr_n = acc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      ref_q   <= '0;
      loss_q  <= 1'b1;
      mferr_q <= 1'b0;
      errc_q  <= '0;
      run_q   <= '0;
    end else begin
      ref_q   <= ref_n;
      loss_q  <= loss_n;
      mferr_q <= mferr_n;
      errc_q  <= errc_n;
      run_q   <= run_n;
    end
  end

  assign loss_d = clr ? 1'b1 : loss_n;
endmodule

// File: rtl/h4mf_alarm_out.sv
module h4mf_alarm_out (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic loss_d,
  input  logic rd_clr,
  output logic lom,
  output logic lom_lat
);
  logic lom_d;
  assign lom_d = active & loss_d;

  always_ff @(posedge clk) begin
    lom <= lom_d;
    if (rst)
      lom_lat <= active;
    else
      lom_lat <= (lom_d & ~lom) | (lom_lat & ~rd_clr);
  end
endmodule

// File: rtl/h4mf_loss_detector.sv
module h4mf_loss_detector
  import h4mf_pkg::*;
#(
  parameter int ERR_MF   = 2,
  parameter int LOCK_RUN = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           fmt_en,
  input  logic           mode_sel,
  input  logic           h4_vld,
  input  logic [H4W-1:0] h4_val,
  input  logic           rd_clr,
  output logic           lom,
  output logic           lom_lat
);
  logic active, clr, loss_d;

  assign active = fmt_en & ~mode_sel;
  assign clr    = rst | ~active;

  h4mf_lock_fsm #(.ERR_MF(ERR_MF), .LOCK_RUN(LOCK_RUN)) u_fsm (
    .clk    (clk),
    .clr    (clr),
    .vld    (h4_vld),
    .val    (h4_val),
    .loss_d (loss_d)
  );

  h4mf_alarm_out u_out (
    .clk     (clk),
    .rst     (rst),
    .active  (active),
    .loss_d  (loss_d),
    .rd_clr  (rd_clr),
    .lom     (lom),
    .lom_lat (lom_lat)
  );
endmodule

// File: rtl/h4mf_loss_detector_chk.sv
module h4mf_loss_detector_chk (
  input logic clk,
  input logic rst,
  input logic fmt_en,
  input logic mode_sel,
  input logic h4_vld,
  input logic rd_clr,
  input logic lom,
  input logic lom_lat
);
  logic act;
  assign act = fmt_en & ~mode_sel;

  // R1
  p_reset_loss_r1: assert property (@(posedge clk) (rst && act) |=> (lom && lom_lat));

  // R8
  p_disabled_zero_r8: assert property (@(posedge clk) disable iff (rst) !act |=> !lom);

  // R6
  p_rise_latches_r6: assert property (@(posedge clk) disable iff (rst) $rose(lom) |-> lom_lat);

  // R6
  p_sticky_hold_r6: assert property (@(posedge clk) disable iff (rst) (lom_lat && !rd_clr) |=> lom_lat);

  // R2, R9
  p_clear_needs_h4_r2: assert property (@(posedge clk) disable iff (rst)
    (act && $past(act) && $fell(lom)) |-> $past(h4_vld));

  // R4, R9
  p_set_needs_h4_r4: assert property (@(posedge clk) disable iff (rst)
    (act && $past(act) && $past(act, 2) && !$past(rst) && $rose(lom)) |-> $past(h4_vld));
endmodule

bind h4mf_loss_detector h4mf_loss_detector_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .fmt_en   (fmt_en),
  .mode_sel (mode_sel),
  .h4_vld   (h4_vld),
  .rd_clr   (rd_clr),
  .lom      (lom),
  .lom_lat  (lom_lat)
);

// File: tb/h4mf_loss_detector_tb.sv
module h4mf_loss_detector_tb;
  localparam int CLK_PER = 10;
  localparam int NV = 37;
  // {rd_clr, h4_vld, h4_val[1:0], exp_lom, exp_lat}
  localparam logic [5:0] VEC [NV] = '{
    6'b1_0_00_1_0,
    6'b0_1_00_1_0, 6'b0_1_01_1_0, 6'b0_1_10_1_0, 6'b0_1_11_0_0,
    6'b0_0_00_0_0,
    6'b0_1_00_0_0, 6'b0_1_01_0_0, 6'b0_1_10_0_0, 6'b0_1_11_0_0,
    6'b0_1_00_0_0, 6'b0_1_01_0_0, 6'b0_1_11_0_0, 6'b0_1_11_0_0,
    6'b0_1_00_0_0, 6'b0_1_01_0_0, 6'b0_1_10_0_0, 6'b0_1_11_0_0,
    6'b0_1_01_0_0, 6'b0_1_01_0_0, 6'b0_1_10_0_0, 6'b0_1_11_0_0,
    6'b0_1_00_0_0, 6'b0_1_00_0_0, 6'b0_1_10_0_0, 6'b0_1_11_1_1,
    6'b1_0_00_1_0,
    6'b0_1_10_1_0, 6'b0_1_11_1_0, 6'b0_1_01_1_0, 6'b0_1_10_1_0,
    6'b0_1_11_1_0, 6'b0_1_00_0_0,
    6'b0_1_01_0_0, 6'b0_1_10_0_0, 6'b0_1_11_0_0, 6'b0_1_00_0_0
  };

  logic clk = 1'b0, rst = 1'b1, fmt_en = 1'b1, mode_sel = 1'b0;
  logic h4_vld = 1'b0, rd_clr = 1'b0;
  logic [1:0] h4_val = 2'd0;
  logic lom, lom_lat;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  h4mf_loss_detector u_dut (
    .clk(clk), .rst(rst), .fmt_en(fmt_en), .mode_sel(mode_sel),
    .h4_vld(h4_vld), .h4_val(h4_val), .rd_clr(rd_clr),
    .lom(lom), .lom_lat(lom_lat)
  );

  function automatic string req_of(input int i);
    if (i == 0 || i == 26) return "R6";
    if (i < 5)  return "R2";
    if (i == 5) return "R5";
    if (i < 18) return "R3";
    if (i < 26) return "R4";
    if (i < 33) return "R2";
    return "R5";
  endfunction

  task automatic check(input string req, input logic el, input logic et);
    checks++;
    if (lom !== el || lom_lat !== et) begin
      fails++;
      $display("FAIL %s lom=%b lom_lat=%b expected lom=%b lom_lat=%b", req, lom, lom_lat, el, et);
    end
  endtask

  task automatic step(input logic c, input logic v, input logic [1:0] d);
    rd_clr = c; h4_vld = v; h4_val = d;
    @(negedge clk);
    rd_clr = 1'b0; h4_vld = 1'b0;
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1 reset", 1'b1, 1'b1);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][5], VEC[i][4], VEC[i][3:2]);
      check($sformatf("%s R9 vec%0d", req_of(i), i), VEC[i][1], VEC[i][0]);
    end
    // counter now 1; two errored multiframes, last strobe with rd_clr (R7)
    step(1'b0, 1'b1, 2'd3); step(1'b0, 1'b1, 2'd3); step(1'b0, 1'b1, 2'd3);
    check("R3 one errored mf", 1'b0, 1'b0);
    step(1'b0, 1'b1, 2'd3); step(1'b0, 1'b1, 2'd3); step(1'b0, 1'b1, 2'd3);
    check("R4 no loss before closing H4", 1'b0, 1'b0);
    step(1'b1, 1'b1, 2'd3);
    check("R7 set wins over clear", 1'b1, 1'b1);
    // disable via mode select (R8)
    mode_sel = 1'b1;
    step(1'b0, 1'b0, 2'd0);
    check("R8 mode_sel forces lom low", 1'b0, 1'b1);
    step(1'b1, 1'b0, 2'd0);
    check("R6 clear while disabled", 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) step(1'b0, 1'b1, 2'(k));
    check("R8 strobes ignored when disabled", 1'b0, 1'b0);
    mode_sel = 1'b0;
    step(1'b0, 1'b0, 2'd0);
    check("R8 re-enable restarts in loss", 1'b1, 1'b1);
    for (int k = 0; k < 3; k++) step(1'b0, 1'b1, 2'(k + 1));
    check("R2 three good values not enough", 1'b1, 1'b1);
    fmt_en = 1'b0;
    step(1'b0, 1'b0, 2'd0);
    check("R8 format disable forces lom low", 1'b0, 1'b1);
    fmt_en = 1'b1;
    step(1'b0, 1'b1, 2'd0);
    check("R8 run lost after disable", 1'b1, 1'b1);
    rst = 1'b1;
    step(1'b1, 1'b0, 2'd0);
    check("R1 reset again", 1'b1, 1'b1);
    done = 1'b1;
  end

  initial begin
    for (int t = 0; t < 2000 && !done; t++) @(negedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule